// File: doc/BRIEF.md
# Multi-mode 4-bit arithmetic unit

This block is a purely combinational arithmetic unit for small words. It takes two operands and a 3-bit operation code. It returns one result word and one flag that marks the result as invalid. The eight operations are: pass either operand, negate either operand, add as unsigned numbers, add as signed numbers, and subtract in either direction as signed numbers. All signed values use two's complement. For the default width of 4 bits, unsigned values run from 0 to 15 and signed values run from -8 to +7.

Each operand goes through its own conditional path. That path can invert the operand and add one, or it can block the operand so that it presents zero. The two paths then feed a single ripple adder whose carry-in is tied low. A small controller decodes the operation code into a negate line and a pass line for each operand. It also forms the invalid flag from the two operand signs, the result sign and the adder carry-out. The flag test depends on the operation. There are no registers, so the outputs follow the inputs within the same evaluation.

Top module: `opu_arith4`

## Requirements
- R1: Operation code 0 drives x_o equal to a_i and holds v_o at 0.
- R2: Operation code 1 drives x_o equal to b_i and holds v_o at 0.
- R3: Operation code 2 drives x_o to the two's-complement negation of a_i modulo 16. v_o is 1 exactly when a_i is 4'b1000 (-8).
- R4: Operation code 3 drives x_o to the two's-complement negation of b_i modulo 16. v_o is 1 exactly when b_i is 4'b1000 (-8).
- R5: Operation code 4 drives x_o to (a_i + b_i) mod 16, with both operands read as unsigned 0..15. v_o is 1 exactly when the true sum exceeds 15; for example 8 + 13 raises it.
- R6: Operation code 5 drives x_o to the low 4 bits of a_i + b_i, with both operands read as signed -8..+7. v_o is 1 exactly when the true signed sum lies outside -8..+7.
- R7: Operation code 6 drives x_o to the low 4 bits of a_i - b_i, read as signed. v_o is 1 exactly when the true difference lies outside -8..+7.
- R8: Operation code 7 drives x_o to the low 4 bits of b_i - a_i, read as signed. v_o is 1 exactly when the true difference lies outside -8..+7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand |
| b_i | input | 4 | Second operand |
| op_i | input | 3 | Operation code, 0..7 as listed in the requirements |
| x_o | output | 4 | Result word |
| v_o | output | 1 | Invalid-result flag |

## Verification
The block holds no state, so a wrong decoded control line or a broken carry shows at x_o or v_o in the same cycle the inputs are applied. A given fault shows only for the operation codes that use the affected path. For example, a swapped pass line hides under the add codes but breaks the pass and negate codes. A flawed overflow term shows only at range corners such as -8 and sums near the limits. For that reason every operand pair is driven under every operation code.

// File: rtl/opu_pkg.sv
// Package: shared operation encoding for the arithmetic unit.
// Assumes a 3-bit operation code; code values are fixed by the unit's behaviour.
package opu_pkg;
    typedef enum logic [2:0] {
        OP_PASS_A = 3'd0,
        OP_PASS_B = 3'd1,
        OP_NEG_A  = 3'd2,
        OP_NEG_B  = 3'd3,
        OP_ADD_U  = 3'd4,
        OP_ADD_S  = 3'd5,
        OP_SUB_AB = 3'd6,
        OP_SUB_BA = 3'd7
    } opu_op_e;
endpackage

// File: rtl/opu_ctrl.sv
// Module: opu_ctrl
// Decodes the operation code into per-operand negate/pass lines and forms the
// invalid flag from operand signs, result sign and adder carry-out.
// Assumes the datapath negates with invert-plus-one and blocks unpassed operands to zero.
module opu_ctrl
    import opu_pkg::*;
(
    input  logic [2:0] op_i,
    input  logic       sign_a_i,
    input  logic       sign_b_i,
    input  logic       sign_x_i,
    input  logic       carry_i,
    output logic       neg_a_o,
    output logic       pass_a_o,
    output logic       neg_b_o,
    output logic       pass_b_o,
    output logic       inv_o
);
    opu_op_e op_e;
    assign op_e = opu_op_e'(op_i);

    // Steering lines for the two operand paths.
    always_comb begin
        neg_a_o  = (op_e == OP_NEG_A) || (op_e == OP_SUB_BA);
        neg_b_o  = (op_e == OP_NEG_B) || (op_e == OP_SUB_AB);
        pass_a_o = op_i[2] | ~op_i[0];
        pass_b_o = op_i[2] |  op_i[0];
    end

    // Invalid-result flag, one test per operation code.
    always_comb begin
        unique case (op_e)
            OP_PASS_A, OP_PASS_B: inv_o = 1'b0;
            OP_NEG_A:  inv_o = sign_a_i & sign_x_i;
            OP_NEG_B:  inv_o = sign_b_i & sign_x_i;
            OP_ADD_U:  inv_o = carry_i;
            OP_ADD_S:  inv_o = (sign_a_i == sign_b_i) && (sign_x_i != sign_a_i);
            OP_SUB_AB: inv_o = (sign_a_i != sign_b_i) && (sign_x_i != sign_a_i);
            OP_SUB_BA: inv_o = (sign_a_i != sign_b_i) && (sign_x_i != sign_b_i);
            default:   inv_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/opu_cond_neg.sv
// Module: opu_cond_neg
// One operand path: optional bitwise inversion, an incrementer that adds the
// negate bit, then a gate that yields zero when the operand is not passed.
// Assumes W >= 2.
module opu_cond_neg #(
    parameter int W = 4
) (
    input  logic [W-1:0] val_i,
    input  logic         neg_i,
    input  logic         pass_i,
    output logic [W-1:0] val_o
);
    logic [W-1:0] inv;
    logic [W-1:0] inc;
    logic [W-1:0] cy;

    // Conditional ones' complement.
    assign inv   = val_i ^ {W{neg_i}};
    assign cy[0] = neg_i;

    // Half-adder chain adding the negate bit.
    for (genvar i = 0; i < W; i++) begin : g_inc
        assign inc[i] = inv[i] ^ cy[i];
        if (i < W - 1) begin : g_cy
            assign cy[i+1] = inv[i] & cy[i];
        end
    end

    // Block the operand when it does not reach the adder.
    assign val_o = pass_i ? inc : '0;
endmodule

// File: rtl/opu_ripple_add.sv
// Module: opu_ripple_add
// Ripple-carry adder built from one full-adder cell per bit.
module opu_ripple_add #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] c;
    assign c[0] = cin_i;

    // Full-adder cells.
    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
        assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
    end

    assign cout_o = c[W];
endmodule

// File: rtl/opu_arith4.sv
// Module: opu_arith4 (top)
// Combinational multi-mode arithmetic unit: two conditional negate paths feed a
// single adder with carry-in tied low; the controller forms the invalid flag.
// Assumes signed operands in two's complement; no clock or state.
module opu_arith4 #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [2:0]   op_i,
    output logic [W-1:0] x_o,
    output logic         v_o
);
    logic         neg_a, pass_a, neg_b, pass_b;
    logic [W-1:0] pa, pb;
    logic         carry;

    opu_ctrl u_ctrl (
        .op_i     (op_i),
        .sign_a_i (a_i[W-1]),
        .sign_b_i (b_i[W-1]),
        .sign_x_i (x_o[W-1]),
        .carry_i  (carry),
        .neg_a_o  (neg_a),
        .pass_a_o (pass_a),
        .neg_b_o  (neg_b),
        .pass_b_o (pass_b),
        .inv_o    (v_o)
    );

    opu_cond_neg #(.W(W)) u_path_a (
        .val_i (a_i), .neg_i (neg_a), .pass_i (pass_a), .val_o (pa)
    );

    opu_cond_neg #(.W(W)) u_path_b (
        .val_i (b_i), .neg_i (neg_b), .pass_i (pass_b), .val_o (pb)
    );

    opu_ripple_add #(.W(W)) u_add (
        .a_i (pa), .b_i (pb), .cin_i (1'b0), .sum_o (x_o), .cout_o (carry)
    );
endmodule

// File: rtl/opu_arith4_chk.sv
// Module: opu_arith4_chk
// Port-level checker for opu_arith4, attached by bind. Compares outputs against
// arithmetic on widened operands, one check group per operation code.
module opu_arith4_chk #(
    parameter int W = 4
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [2:0]   op_i,
    input logic [W-1:0] x_o,
    input logic         v_o
);
    logic [W:0]   usum, ssum, sab, sba, na, nb;
    logic [W-1:0] minv;

    // Widened reference quantities.
    always_comb begin
        minv = {1'b1, {(W-1){1'b0}}};
        usum = {1'b0, a_i} + {1'b0, b_i};
        ssum = {a_i[W-1], a_i} + {b_i[W-1], b_i};
        sab  = {a_i[W-1], a_i} - {b_i[W-1], b_i};
        sba  = {b_i[W-1], b_i} - {a_i[W-1], a_i};
        na   = '0 - {a_i[W-1], a_i};
        nb   = '0 - {b_i[W-1], b_i};
    end

    // Per-operation immediate checks.
    always_comb begin
        if (op_i == 3'd0) assert_pass_a_R1: assert (x_o == a_i && !v_o);
        if (op_i == 3'd1) assert_pass_b_R2: assert (x_o == b_i && !v_o);
        if (op_i == 3'd2) assert_neg_a_R3:  assert (x_o == na[W-1:0] && v_o == (a_i == minv));
        if (op_i == 3'd3) assert_neg_b_R4:  assert (x_o == nb[W-1:0] && v_o == (b_i == minv));
        if (op_i == 3'd4) assert_add_u_R5:  assert ({v_o, x_o} == usum);
        if (op_i == 3'd5) assert_add_s_R6:  assert (x_o == ssum[W-1:0] && v_o == (ssum[W] != ssum[W-1]));
        if (op_i == 3'd6) assert_sub_ab_R7: assert (x_o == sab[W-1:0] && v_o == (sab[W] != sab[W-1]));
        if (op_i == 3'd7) assert_sub_ba_R8: assert (x_o == sba[W-1:0] && v_o == (sba[W] != sba[W-1]));
    end
endmodule

bind opu_arith4 opu_arith4_chk #(.W(W)) u_chk (
    .a_i (a_i), .b_i (b_i), .op_i (op_i), .x_o (x_o), .v_o (v_o)
);

// File: tb/opu_arith4_test.sv
// Bench: scoreboard for opu_arith4. The driver applies every opcode/operand
// combination and queues the expected result; the monitor compares them.
module opu_arith4_test;
    typedef struct {
        int    op;
        int    a;
        int    b;
        int    x;
        int    v;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] a_i = '0, b_i = '0;
    logic [2:0] op_i = '0;
    logic [3:0] x_o;
    logic       v_o;

    int   compared = 0, mismatched = 0;
    bit   done = 0;
    exp_t sb_q[$];

    opu_arith4 uut (.a_i(a_i), .b_i(b_i), .op_i(op_i), .x_o(x_o), .v_o(v_o));

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    // Reference model computed from the requirements.
    function automatic exp_t ref_model(int o, int ai, int bi);
        exp_t e;
        int sa, sbv, r;
        sa  = (ai >= 8) ? ai - 16 : ai;
        sbv = (bi >= 8) ? bi - 16 : bi;
        e.op = o; e.a = ai; e.b = bi; e.v = 0;
        case (o)
            0: begin r = ai;       e.req = "R1"; end
            1: begin r = bi;       e.req = "R2"; end
            2: begin r = -sa;      e.req = "R3"; e.v = (r > 7) ? 1 : 0; end
            3: begin r = -sbv;     e.req = "R4"; e.v = (r > 7) ? 1 : 0; end
            4: begin r = ai + bi;  e.req = "R5"; e.v = (r > 15) ? 1 : 0; end
            5: begin r = sa + sbv; e.req = "R6"; e.v = (r > 7 || r < -8) ? 1 : 0; end
            6: begin r = sa - sbv; e.req = "R7"; e.v = (r > 7 || r < -8) ? 1 : 0; end
            default: begin r = sbv - sa; e.req = "R8"; e.v = (r > 7 || r < -8) ? 1 : 0; end
        endcase
        e.x = r & 15;
        return e;
    endfunction

    // Driver: apply one vector after a rising edge and queue its expectation.
    task automatic drive(int o, int ai, int bi);
        @(posedge clk);
        op_i = 3'(o); a_i = 4'(ai); b_i = 4'(bi);
        sb_q.push_back(ref_model(o, ai, bi));
    endtask

    // Monitor: compare at the falling edge, away from input changes.
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            compared++;
            if (int'(x_o) != e.x || int'(v_o) != e.v) begin
                mismatched++;
                $display("FAIL %s op=%0d a=%0d b=%0d: x=%0d v=%0d expected x=%0d v=%0d",
                         e.req, e.op, e.a, e.b, x_o, v_o, e.x, e.v);
            end
        end
    end

    // Stimulus: explicit corners first (R3 -8, R5 8+13), then exhaustive sweep.
    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        drive(0, 0, 0);     // R1 idle vector
        drive(2, 8, 0);     // R3 negate -8
        drive(3, 0, 8);     // R4 negate -8
        drive(4, 8, 13);    // R5 unsigned carry
        drive(5, 6, 5);     // R6 positive overflow
        drive(6, 4, 10);    // R7 4 - (-6)
        drive(7, 14, 6);    // R8 6 - (-2)
        for (int o = 0; o < 8; o++)
            for (int ai = 0; ai < 16; ai++)
                for (int bi = 0; bi < 16; bi++)
                    drive(o, ai, bi);
        repeat (3) @(posedge clk);
        if (compared != 7 + 2048) begin
            mismatched++;
            $display("FAIL R1 vector count: actual %0d expected %0d", compared, 7 + 2048);
        end
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            mismatched++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule